// File: doc/BRIEF.md
# Region Cache Attribute Protection Unit

This unit guards a flat 32-bit address space in which physical and virtual addresses are the same. The space is cut into eight equal 512 MB regions. One 32-bit attribute register holds a 4-bit code for each region. Every instruction fetch, load or store that reaches the unit is checked against the code of its region. In the same cycle the unit answers with a grant or a fault, and it reports the cache policy that applies to that region.

Software reaches the attribute register through a small special-register port. The port carries a register number, a write strobe and write data, and it returns read data as a combinational value. The unit answers only to register number 98. The attribute codes form a sparse table: six codes carry a meaning and all the others deny every kind of access. The unit has no state machine. Its only state is the attribute register, and all checking is combinational from that register and the request.

Top module: `region_prot_unit`

## Requirements
- R1: While reset is asserted and afterwards until the first write, the attribute register holds 0x22222222, and reading register number 98 returns that value.
- R2: A write with `sr_num` equal to 98 changes the register at the clock edge. Requests and reads see the new value from the next cycle on, and a read in the same cycle as a write still returns the old value. A read of 98 returns all 32 bits last written. Writes to any other number leave the register unchanged, and reads of any other number return 0.
- R3: Address bits [31:29] give the region number n, and region n uses register bits [4n+3:4n]. Address bits [28:0] have no effect.
- R4: `req_policy` is encoded as 0 none, 1 write-through, 2 write-back, 3 bypass, 4 isolate. Code 0 gives read and write with write-through. Code 1 gives read, write and execute with write-through. Code 2 gives read, write and execute with bypass.
- R5: Code 3 gives execute only with write-back, so loads and stores to such a region fault. Code 4 gives read, write and execute with write-back.
- R6: Code 14 gives read and write but not execute, with policy isolate.
- R7: Codes 5 to 13 and 15 give no permission at all and report policy none. Every request to such a region faults.
- R8: `req_type` is encoded as 0 fetch, 1 load, 2 store and 3 reserved. A fetch needs execute, a load needs read and a store needs write. A reserved type always faults.
- R9: When `req_valid` is high, exactly one of `req_grant` and `req_fault` is high in the same cycle as the request. When `req_valid` is low, both are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sr_num | input | 8 | Special-register number for the read or write |
| sr_wr_en | input | 1 | Write strobe |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Read data; the attribute register when `sr_num` is 98, else 0 |
| req_valid | input | 1 | Request present |
| req_type | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved |
| req_addr | input | 32 | Request address |
| req_grant | output | 1 | Access allowed |
| req_fault | output | 1 | Access denied |
| req_policy | output | 3 | Cache policy of the addressed region |

## Verification
The bench places each of the sixteen codes in each of the eight regions and fills the other regions with a different code. It then issues all four request types with random low address bits. A design that takes the wrong nibble, or that reacts to bits below 29, would then report the neighbour's permission. Code 3 with a load or store, and code 14 with a fetch, are the asymmetric cases: a decoder that treats every defined code as full access would grant these where the design must fault. Writes to other register numbers, reads of other numbers and reads in the same cycle as a write are mixed in. These cases expose a register that decodes the number loosely, or a read path that returns the data being written instead of the stored value.

// File: rtl/rpu_pkg.sv
package rpu_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        POL_NONE    = 3'd0,
        POL_WTHRU   = 3'd1,
        POL_WBACK   = 3'd2,
        POL_BYPASS  = 3'd3,
        POL_ISOLATE = 3'd4
    } pol_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

endpackage

// File: rtl/rpu_attr_reg.sv
module rpu_attr_reg #(
    parameter int               REG_W     = 32,
    parameter logic [REG_W-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (wr_en) begin
            q <= wdata;
        end
    end

    // R2
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && rst_n) |-> (q == $past(wdata)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wr_en && rst_n) |-> $stable(q));

endmodule

// File: rtl/rpu_region_sel.sv
module rpu_region_sel #(
    parameter int REGION_BITS = 3,
    parameter int ATTR_W      = 4,
    localparam int N_REGIONS  = 1 << REGION_BITS,
    localparam int REG_W      = N_REGIONS * ATTR_W
) (
    input  logic [REG_W-1:0]       attr_reg,
    input  logic [REGION_BITS-1:0] region,
    output logic [ATTR_W-1:0]      attr
);

    logic [ATTR_W-1:0] field [N_REGIONS];

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_field
        assign field[g] = attr_reg[g*ATTR_W +: ATTR_W];
    end

    assign attr = field[region];

endmodule

// File: rtl/rpu_attr_decode.sv
module rpu_attr_decode
    import rpu_pkg::*;
(
    input  logic [3:0] attr,
    output perm_t      perm,
    output pol_e       pol
);

    always_comb begin
        perm = '0;
        pol  = POL_NONE;
        unique case (attr)
            4'd0: begin
                perm = '{x: 1'b0, w: 1'b1, r: 1'b1};
                pol  = POL_WTHRU;
            end
            4'd1: begin
                perm = '{x: 1'b1, w: 1'b1, r: 1'b1};
                pol  = POL_WTHRU;
            end
            4'd2: begin
                perm = '{x: 1'b1, w: 1'b1, r: 1'b1};
                pol  = POL_BYPASS;
            end
            4'd3: begin
                perm = '{x: 1'b1, w: 1'b0, r: 1'b0};
                pol  = POL_WBACK;
            end
            4'd4: begin
                perm = '{x: 1'b1, w: 1'b1, r: 1'b1};
                pol  = POL_WBACK;
            end
            4'd14: begin
                perm = '{x: 1'b0, w: 1'b1, r: 1'b1};
                pol  = POL_ISOLATE;
            end
            default: begin
                perm = '0;
                pol  = POL_NONE;
            end
        endcase
    end

    // R7
    always_comb begin
        none_no_perm_chk: assert (pol != POL_NONE || perm == '0);
    end

endmodule

// File: rtl/region_prot_unit.sv
module region_prot_unit
    import rpu_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              REGION_BITS = 3,
    parameter int              ATTR_W      = 4,
    parameter int              SR_NUM_W    = 8,
    parameter int              SR_ATTR_NUM = 98,
    parameter logic [31:0]     RESET_VAL   = 32'h2222_2222
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          sr_num,
    input  logic                sr_wr_en,
    input  logic [31:0]         sr_wdata,
    output logic [31:0]         sr_rdata,
    input  logic                req_valid,
    input  logic [1:0]          req_type,
    input  logic [31:0]         req_addr,
    output logic                req_grant,
    output logic                req_fault,
    output logic [2:0]          req_policy
);

    localparam int N_REGIONS = 1 << REGION_BITS;
    localparam int REG_W     = N_REGIONS * ATTR_W;
    localparam int LOW_W     = ADDR_W - REGION_BITS;

    logic [REG_W-1:0]       attr_q;
    logic                   sel_hit;
    logic [REGION_BITS-1:0] region;
    logic [ATTR_W-1:0]      attr;
    perm_t                  perm;
    pol_e                   pol;
    logic                   allowed;
    logic                   unused_low_addr;

    assign sel_hit = (sr_num == SR_NUM_W'(SR_ATTR_NUM));

    rpu_attr_reg #(
        .REG_W     (REG_W),
        .RESET_VAL (RESET_VAL)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sr_wr_en && sel_hit),
        .wdata (sr_wdata),
        .q     (attr_q)
    );

    assign sr_rdata = sel_hit ? attr_q : '0;

    assign region          = req_addr[ADDR_W-1 -: REGION_BITS];
    assign unused_low_addr = ^req_addr[LOW_W-1:0];

    rpu_region_sel #(
        .REGION_BITS (REGION_BITS),
        .ATTR_W      (ATTR_W)
    ) u_sel (
        .attr_reg (attr_q),
        .region   (region),
        .attr     (attr)
    );

    rpu_attr_decode u_dec (
        .attr (attr),
        .perm (perm),
        .pol  (pol)
    );

    always_comb begin
        unique case (acc_e'(req_type))
            ACC_FETCH: allowed = perm.x;
            ACC_LOAD:  allowed = perm.r;
            ACC_STORE: allowed = perm.w;
            default:   allowed = 1'b0;
        endcase
    end

    assign req_grant  = req_valid &&  allowed;
    assign req_fault  = req_valid && !allowed;
    assign req_policy = pol;

    // R9
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_grant && req_fault));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_grant && !req_fault));

    // R8
    rsvd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type == 2'd3) |-> req_fault);

    // R7
    none_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_policy == 3'd0) |-> req_fault);

    // R6
    isolate_noexec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type == 2'd0 && req_policy == 3'd4) |-> req_fault);

endmodule

// File: tb/test_region_prot_unit.sv
module test_region_prot_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  sr_num;
    logic        sr_wr_en;
    logic [31:0] sr_wdata;
    logic [31:0] sr_rdata;
    logic        req_valid;
    logic [1:0]  req_type;
    logic [31:0] req_addr;
    logic        req_grant;
    logic        req_fault;
    logic [2:0]  req_policy;

    int n_vec  = 0;
    int n_fail = 0;
    logic [31:0] model_reg;

    always #5 clk = ~clk;

    region_prot_unit i_region_prot_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_num     (sr_num),
        .sr_wr_en   (sr_wr_en),
        .sr_wdata   (sr_wdata),
        .sr_rdata   (sr_rdata),
        .req_valid  (req_valid),
        .req_type   (req_type),
        .req_addr   (req_addr),
        .req_grant  (req_grant),
        .req_fault  (req_fault),
        .req_policy (req_policy)
    );

    // Behavioural expectation built from the requirement text
    function automatic void expect_req(input logic [31:0] regv, input logic [31:0] addr,
                                       input logic [1:0] typ, input logic valid,
                                       output logic g, output logic f,
                                       output logic [2:0] p, output string tag);
        int nib;
        bit r, w, x;
        nib = int'((regv >> (int'(addr[31:29]) * 4)) & 32'hf);
        r = 0; w = 0; x = 0; p = 3'd0;
        if (nib == 0)       begin r = 1; w = 1;        p = 3'd1; tag = "R4"; end
        else if (nib == 1)  begin r = 1; w = 1; x = 1; p = 3'd1; tag = "R4"; end
        else if (nib == 2)  begin r = 1; w = 1; x = 1; p = 3'd3; tag = "R4"; end
        else if (nib == 3)  begin x = 1;               p = 3'd2; tag = "R5"; end
        else if (nib == 4)  begin r = 1; w = 1; x = 1; p = 3'd2; tag = "R5"; end
        else if (nib == 14) begin r = 1; w = 1;        p = 3'd4; tag = "R6"; end
        else                tag = "R7";
        tag = {tag, "+R3"};
        g = 0;
        if (typ == 2'd0) g = x;
        else if (typ == 2'd1) g = r;
        else if (typ == 2'd2) g = w;
        else tag = "R8";
        if (!valid) tag = "R9";
        f = valid && !g;
        g = valid && g;
    endfunction

    task automatic apply(input logic valid, input logic [1:0] typ, input logic [31:0] addr,
                         input logic wr, input logic [7:0] num, input logic [31:0] wd);
        logic eg, ef;
        logic [2:0] ep;
        logic [31:0] er;
        string tag;
        req_valid = valid; req_type = typ; req_addr = addr;
        sr_wr_en = wr; sr_num = num; sr_wdata = wd;
        #4;
        expect_req(model_reg, addr, typ, valid, eg, ef, ep, tag);
        er = (num == 8'd98) ? model_reg : 32'h0;
        n_vec++;
        if (req_grant !== eg || req_fault !== ef || req_policy !== ep || sr_rdata !== er) begin
            n_fail++;
            if (sr_rdata !== er)
                $display("FAIL R2 rdata num=%0d actual=%h expected=%h", num, sr_rdata, er);
            else
                $display("FAIL %s addr=%h type=%0d actual g/f/p=%b/%b/%0d expected=%b/%b/%0d",
                         tag, addr, typ, req_grant, req_fault, req_policy, eg, ef, ep);
        end
        @(posedge clk);
        if (wr && num == 8'd98) model_reg = wd;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        model_reg = 32'h2222_2222;
        rst_n = 1'b0;
        req_valid = 0; req_type = 0; req_addr = 0;
        sr_wr_en = 0; sr_num = 8'd98; sr_wdata = 0;
        repeat (3) @(negedge clk);
        // R1: reset value visible while reset is held
        #4;
        n_vec++;
        if (sr_rdata !== 32'h2222_2222) begin
            n_fail++;
            $display("FAIL R1 actual=%h expected=22222222", sr_rdata);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1: bypass everywhere after reset
        for (int rg = 0; rg < 8; rg++)
            for (int t = 0; t < 4; t++)
                apply(1'b1, 2'(t), {3'(rg), 29'($urandom)}, 1'b0, 8'd98, 32'h0);
        // R9: idle requests
        for (int k = 0; k < 8; k++)
            apply(1'b0, 2'(k), $urandom, 1'b0, 8'd98, 32'h0);
        // R3..R8: every code in every region, other regions filled differently
        for (int rg = 0; rg < 8; rg++) begin
            for (int a = 0; a < 16; a++) begin
                logic [31:0] v;
                v = {8{4'(15 - a)}};
                v[rg*4 +: 4] = 4'(a);
                apply(1'b0, 2'd0, 32'h0, 1'b1, 8'd98, v);
                for (int t = 0; t < 4; t++)
                    apply(1'b1, 2'(t), {3'(rg), 29'($urandom)}, 1'b0, 8'd98, 32'h0);
            end
        end
        // R2: writes to other numbers ignored, reads of other numbers give 0
        for (int k = 0; k < 40; k++) begin
            logic [7:0] num;
            num = 8'($urandom);
            if (num == 8'd98) num = 8'd99;
            apply(1'b1, 2'($urandom), $urandom, 1'b1, num, $urandom);
            apply(1'b1, 2'($urandom), $urandom, 1'b0, 8'd98, 32'h0);
        end
        // R2: back-to-back writes with same-cycle reads
        for (int k = 0; k < 300; k++)
            apply(1'($urandom), 2'($urandom), $urandom, 1'($urandom),
                  ((k % 3) == 0) ? 8'($urandom) : 8'd98, $urandom);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule